// File: doc/BRIEF.md
# Tagged Ternary Segment Cache Pipeline

This block resolves a packet header by walking it through a fixed chain of lookup stages, each holding a small ternary table of cached pipeline segments. A header word and a segment tag enter at the head of the chain. Every stage forms its key from the current tag and the header and searches its entries under a per-entry care mask. The winning entry rewrites chosen header bits, loads the tag of the next cached segment and can declare that it also covers some of the following stages. A packet for which no cached segment matches is flagged so that the surrounding logic can hand it to the software slow path.

Priorities are assigned by whoever fills the tables, so that a segment covering more pipeline tables outranks a shorter one that overlaps it. A reserved tag marks a finished traversal; from then on the remaining stages let the packet through untouched. The chain takes one packet per cycle under a valid/ready handshake. Its latency is one cycle per stage, and the tables are written entry by entry through a configuration port while no packet is in flight.

Top module: `ltm_cache_pipe`

## Requirements
- R1: After reset `out_valid` is 0, `in_ready` is 1 and every table entry is invalid, so a packet with any tag other than 15 ends up marked as a miss, with its header and tag unchanged.
- R2: An entry matches when `entry_valid` is set and `(({tag,hdr} ^ {key_tag,key_hdr}) & {care_tag,care_hdr}) == 0`. The tag occupies the upper 4 bits of the 36-bit key, and a care bit of 1 means the bit is compared.
- R3: Among matching entries the one with the largest 3-bit priority wins. Between equal priorities, the entry with the lowest slot index wins.
- R4: On a hit the header becomes `(hdr & ~set_mask) | (set_val & set_mask)` and the tag becomes the entry's next tag.
- R5: Each stage matches on the tag produced by the stage before it, so segments chain from stage 0 through the last stage.
- R6: Tag value 15 (all ones) is reserved for a completed traversal. A stage that receives it performs no lookup and forwards the header, tag and miss flag unchanged, and never raises a miss.
- R7: An entry's 3-bit skip field S makes the next S stages pass the packet through without a lookup, with header and tag unchanged.
- R8: A stage that performs a lookup and finds no match sets the miss flag. Header and tag keep the values they had on reaching that stage, and all later stages forward the packet unchanged.
- R9: With `out_ready` held at 1 the chain accepts one packet per cycle, and each result appears NUM_STAGES cycles after acceptance, in order. While `out_valid` is 1 and `out_ready` is 0, the outputs hold and no new packet is accepted.
- R10: A write with `cfg_wr` set loads slot `cfg_slot` of stage `cfg_stage` with all of its fields. Writing `cfg_entry_valid` = 0 removes that entry from matching.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input packet present |
| in_ready | output | 1 | Chain can take a packet this cycle |
| in_hdr | input | 32 | Header vector |
| in_tag | input | 4 | Initial segment tag from the parser |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Downstream takes the result |
| out_hdr | output | 32 | Rewritten header |
| out_tag | output | 4 | Final tag |
| out_miss | output | 1 | No cached segment matched; send to slow path |
| cfg_wr | input | 1 | Table write strobe |
| cfg_stage | input | 2 | Stage selected for the write |
| cfg_slot | input | 3 | Entry index within the stage |
| cfg_entry_valid | input | 1 | Entry valid bit |
| cfg_key_tag | input | 4 | Tag part of the match value |
| cfg_key_hdr | input | 32 | Header part of the match value |
| cfg_care_tag | input | 4 | Tag compare mask |
| cfg_care_hdr | input | 32 | Header compare mask |
| cfg_prio | input | 3 | Entry priority |
| cfg_next_tag | input | 4 | Tag loaded on a hit |
| cfg_skip | input | 3 | Number of following stages passed through |
| cfg_set_val | input | 32 | Header rewrite value |
| cfg_set_mask | input | 32 | Header bits replaced on a hit |

## Verification
Four properties are checked on every cycle. A stalled result stays put with its valid held. The count of packets inside the chain never exceeds the stage count. No result appears unless a packet is in flight, and a missed packet never carries the completion tag. Ternary matching, priority and tie order, tag chaining, skipping and rewrite values depend on the table contents. Those can be shown only by the bench's scenarios, which use directed tables with known answers and random tables with random packets scored against a bench model.

// File: rtl/ltm_cache_pkg.sv
package ltm_cache_pkg;
  localparam int unsigned DEF_HDR_W   = 32;
  localparam int unsigned DEF_TAG_W   = 4;
  localparam int unsigned DEF_STAGES  = 4;
  localparam int unsigned DEF_ENTRIES = 8;
  localparam int unsigned DEF_PRIO_W  = 3;
  localparam int unsigned DEF_SKIP_W  = 3;
endpackage

// File: rtl/ltm_seg_table.sv
module ltm_seg_table
  import ltm_cache_pkg::*;
#(
  parameter int unsigned HDR_W   = DEF_HDR_W,
  parameter int unsigned TAG_W   = DEF_TAG_W,
  parameter int unsigned ENTRIES = DEF_ENTRIES,
  parameter int unsigned PRIO_W  = DEF_PRIO_W,
  parameter int unsigned SKIP_W  = DEF_SKIP_W,
  localparam int unsigned IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1,
  localparam int unsigned KEY_W  = TAG_W + HDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic              wr_vld,
  input  logic [KEY_W-1:0]  wr_key,
  input  logic [KEY_W-1:0]  wr_care,
  input  logic [PRIO_W-1:0] wr_prio,
  input  logic [TAG_W-1:0]  wr_ntag,
  input  logic [SKIP_W-1:0] wr_skip,
  input  logic [HDR_W-1:0]  wr_sval,
  input  logic [HDR_W-1:0]  wr_smask,
  input  logic [KEY_W-1:0]  lk_key,
  output logic              lk_hit,
  output logic [TAG_W-1:0]  lk_ntag,
  output logic [SKIP_W-1:0] lk_skip,
  output logic [HDR_W-1:0]  lk_sval,
  output logic [HDR_W-1:0]  lk_smask
);
  logic              vld_q  [ENTRIES];
  logic              vld_d  [ENTRIES];
  logic [KEY_W-1:0]  key_q  [ENTRIES];
  logic [KEY_W-1:0]  care_q [ENTRIES];
  logic [PRIO_W-1:0] prio_q [ENTRIES];
  logic [TAG_W-1:0]  ntag_q [ENTRIES];
  logic [SKIP_W-1:0] skip_q [ENTRIES];
  logic [HDR_W-1:0]  sval_q [ENTRIES];
  logic [HDR_W-1:0]  smsk_q [ENTRIES];
  logic [ENTRIES-1:0] match;

  always_comb begin
    for (int e = 0; e < ENTRIES; e++) begin
      vld_d[e] = vld_q[e];
      if (wr_en && (wr_idx == IDX_W'(e))) vld_d[e] = wr_vld;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int e = 0; e < ENTRIES; e++) vld_q[e] <= 1'b0;
    end else begin
      for (int e = 0; e < ENTRIES; e++) vld_q[e] <= vld_d[e];
    end
  end

  generate
    for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
      logic ld;
      assign ld = wr_en && (wr_idx == IDX_W'(e));
      always_ff @(posedge clk) begin
        if (ld) begin
          key_q[e]  <= wr_key;
          care_q[e] <= wr_care;
          prio_q[e] <= wr_prio;
          ntag_q[e] <= wr_ntag;
          skip_q[e] <= wr_skip;
          sval_q[e] <= wr_sval;
          smsk_q[e] <= wr_smask;
        end
      end
      assign match[e] = vld_q[e] && (((lk_key ^ key_q[e]) & care_q[e]) == '0);
    end
  endgenerate

  // Ascending scan with a strict compare keeps the lowest index on ties.
  always_comb begin
    logic [PRIO_W-1:0] best;
    logic [IDX_W-1:0]  sel;
    lk_hit = 1'b0;
    best   = '0;
    sel    = '0;
    for (int e = 0; e < ENTRIES; e++) begin
      if (match[e] && (!lk_hit || (prio_q[e] > best))) begin
        lk_hit = 1'b1;
        best   = prio_q[e];
        sel    = IDX_W'(e);
      end
    end
    lk_ntag  = ntag_q[sel];
    lk_skip  = skip_q[sel];
    lk_sval  = sval_q[sel];
    lk_smask = smsk_q[sel];
  end
endmodule

// File: rtl/ltm_stage.sv
module ltm_stage
  import ltm_cache_pkg::*;
#(
  parameter int unsigned HDR_W   = DEF_HDR_W,
  parameter int unsigned TAG_W   = DEF_TAG_W,
  parameter int unsigned ENTRIES = DEF_ENTRIES,
  parameter int unsigned PRIO_W  = DEF_PRIO_W,
  parameter int unsigned SKIP_W  = DEF_SKIP_W,
  localparam int unsigned IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1,
  localparam int unsigned KEY_W  = TAG_W + HDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              adv,
  input  logic              i_vld,
  input  logic [HDR_W-1:0]  i_hdr,
  input  logic [TAG_W-1:0]  i_tag,
  input  logic              i_miss,
  input  logic [SKIP_W-1:0] i_skip,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic              wr_vld,
  input  logic [KEY_W-1:0]  wr_key,
  input  logic [KEY_W-1:0]  wr_care,
  input  logic [PRIO_W-1:0] wr_prio,
  input  logic [TAG_W-1:0]  wr_ntag,
  input  logic [SKIP_W-1:0] wr_skip,
  input  logic [HDR_W-1:0]  wr_sval,
  input  logic [HDR_W-1:0]  wr_smask,
  output logic              o_vld,
  output logic [HDR_W-1:0]  o_hdr,
  output logic [TAG_W-1:0]  o_tag,
  output logic              o_miss,
  output logic [SKIP_W-1:0] o_skip
);
  localparam logic [TAG_W-1:0] TAG_DONE = '1;

  logic              hit;
  logic [TAG_W-1:0]  h_ntag;
  logic [SKIP_W-1:0] h_skip;
  logic [HDR_W-1:0]  h_sval, h_smask;
  logic              bypass;
  logic [HDR_W-1:0]  n_hdr;
  logic [TAG_W-1:0]  n_tag;
  logic              n_miss;
  logic [SKIP_W-1:0] n_skip;

  ltm_seg_table #(
    .HDR_W(HDR_W), .TAG_W(TAG_W), .ENTRIES(ENTRIES),
    .PRIO_W(PRIO_W), .SKIP_W(SKIP_W)
  ) u_tbl (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_vld(wr_vld), .wr_key(wr_key),
    .wr_care(wr_care), .wr_prio(wr_prio), .wr_ntag(wr_ntag),
    .wr_skip(wr_skip), .wr_sval(wr_sval), .wr_smask(wr_smask),
    .lk_key({i_tag, i_hdr}), .lk_hit(hit), .lk_ntag(h_ntag),
    .lk_skip(h_skip), .lk_sval(h_sval), .lk_smask(h_smask)
  );

  always_comb begin
    bypass = i_miss || (i_tag == TAG_DONE) || (i_skip != '0);
    n_hdr  = i_hdr;
    n_tag  = i_tag;
    n_miss = i_miss;
    n_skip = i_skip;
    if (bypass) begin
      if (i_skip != '0) n_skip = i_skip - 1'b1;
    end else if (hit) begin
      n_hdr  = (i_hdr & ~h_smask) | (h_sval & h_smask);
      n_tag  = h_ntag;
      n_skip = h_skip;
    end else begin
      n_miss = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      o_vld  <= 1'b0;
      o_hdr  <= '0;
      o_tag  <= '0;
      o_miss <= 1'b0;
      o_skip <= '0;
    end else if (adv) begin
      o_vld  <= i_vld;
      o_hdr  <= n_hdr;
      o_tag  <= n_tag;
      o_miss <= n_miss;
      o_skip <= n_skip;
    end
  end
endmodule

// File: rtl/ltm_cache_pipe.sv
module ltm_cache_pipe
  import ltm_cache_pkg::*;
#(
  parameter int unsigned HDR_W   = DEF_HDR_W,
  parameter int unsigned TAG_W   = DEF_TAG_W,
  parameter int unsigned STAGES  = DEF_STAGES,
  parameter int unsigned ENTRIES = DEF_ENTRIES,
  parameter int unsigned PRIO_W  = DEF_PRIO_W,
  parameter int unsigned SKIP_W  = DEF_SKIP_W,
  localparam int unsigned STG_W  = (STAGES > 1) ? $clog2(STAGES) : 1,
  localparam int unsigned IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [HDR_W-1:0]  in_hdr,
  input  logic [TAG_W-1:0]  in_tag,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [HDR_W-1:0]  out_hdr,
  output logic [TAG_W-1:0]  out_tag,
  output logic              out_miss,
  input  logic              cfg_wr,
  input  logic [STG_W-1:0]  cfg_stage,
  input  logic [IDX_W-1:0]  cfg_slot,
  input  logic              cfg_entry_valid,
  input  logic [TAG_W-1:0]  cfg_key_tag,
  input  logic [HDR_W-1:0]  cfg_key_hdr,
  input  logic [TAG_W-1:0]  cfg_care_tag,
  input  logic [HDR_W-1:0]  cfg_care_hdr,
  input  logic [PRIO_W-1:0] cfg_prio,
  input  logic [TAG_W-1:0]  cfg_next_tag,
  input  logic [SKIP_W-1:0] cfg_skip,
  input  logic [HDR_W-1:0]  cfg_set_val,
  input  logic [HDR_W-1:0]  cfg_set_mask
);
  logic              adv;
  logic              p_vld  [STAGES+1];
  logic [HDR_W-1:0]  p_hdr  [STAGES+1];
  logic [TAG_W-1:0]  p_tag  [STAGES+1];
  logic              p_miss [STAGES+1];
  logic [SKIP_W-1:0] p_skip [STAGES+1];

  // The whole chain moves together; a stalled tail freezes every stage.
  assign adv      = !out_valid || out_ready;
  assign in_ready = adv;

  assign p_vld[0]  = in_valid;
  assign p_hdr[0]  = in_hdr;
  assign p_tag[0]  = in_tag;
  assign p_miss[0] = 1'b0;
  assign p_skip[0] = '0;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stg
      logic sel;
      assign sel = cfg_wr && (cfg_stage == STG_W'(s));
      ltm_stage #(
        .HDR_W(HDR_W), .TAG_W(TAG_W), .ENTRIES(ENTRIES),
        .PRIO_W(PRIO_W), .SKIP_W(SKIP_W)
      ) u_stage (
        .clk(clk), .rst_n(rst_n), .adv(adv),
        .i_vld(p_vld[s]), .i_hdr(p_hdr[s]), .i_tag(p_tag[s]),
        .i_miss(p_miss[s]), .i_skip(p_skip[s]),
        .wr_en(sel), .wr_idx(cfg_slot), .wr_vld(cfg_entry_valid),
        .wr_key({cfg_key_tag, cfg_key_hdr}),
        .wr_care({cfg_care_tag, cfg_care_hdr}),
        .wr_prio(cfg_prio), .wr_ntag(cfg_next_tag), .wr_skip(cfg_skip),
        .wr_sval(cfg_set_val), .wr_smask(cfg_set_mask),
        .o_vld(p_vld[s+1]), .o_hdr(p_hdr[s+1]), .o_tag(p_tag[s+1]),
        .o_miss(p_miss[s+1]), .o_skip(p_skip[s+1])
      );
    end
  endgenerate

  assign out_valid = p_vld[STAGES];
  assign out_hdr   = p_hdr[STAGES];
  assign out_tag   = p_tag[STAGES];
  assign out_miss  = p_miss[STAGES];
endmodule

// File: rtl/ltm_cache_pipe_chk.sv
module ltm_cache_pipe_chk #(
  parameter int unsigned HDR_W  = 32,
  parameter int unsigned TAG_W  = 4,
  parameter int unsigned STAGES = 4,
  localparam int unsigned CNT_W = $clog2(STAGES + 2) + 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic             out_valid,
  input logic             out_ready,
  input logic [HDR_W-1:0] out_hdr,
  input logic [TAG_W-1:0] out_tag,
  input logic             out_miss
);
  localparam logic [TAG_W-1:0] TAG_DONE = '1;
  logic [CNT_W-1:0] inflight_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) inflight_q <= '0;
    else inflight_q <= inflight_q + CNT_W'(in_valid && in_ready)
                                  - CNT_W'(out_valid && out_ready);
  end

  // R9
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_hdr) && $stable(out_tag) && $stable(out_miss));

  // R9
  inflight_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inflight_q <= CNT_W'(STAGES));

  // R9
  no_phantom_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> inflight_q != '0);

  // R6
  miss_not_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_miss |-> out_tag != TAG_DONE);
endmodule

bind ltm_cache_pipe ltm_cache_pipe_chk #(
  .HDR_W(HDR_W), .TAG_W(TAG_W), .STAGES(STAGES)
) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_hdr(out_hdr),
  .out_tag(out_tag), .out_miss(out_miss)
);

// File: tb/ltm_cache_pipe_test.sv
module ltm_cache_pipe_test;
  localparam int CLK_PERIOD = 10;
  localparam int NS = 4;
  localparam int NE = 8;

  logic clk, rst_n;
  logic in_valid, in_ready, out_valid, out_ready, out_miss;
  logic [31:0] in_hdr, out_hdr;
  logic [3:0]  in_tag, out_tag;
  logic cfg_wr, cfg_entry_valid;
  logic [1:0] cfg_stage;
  logic [2:0] cfg_slot, cfg_prio, cfg_skip;
  logic [3:0] cfg_key_tag, cfg_care_tag, cfg_next_tag;
  logic [31:0] cfg_key_hdr, cfg_care_hdr, cfg_set_val, cfg_set_mask;

  int checks = 0, fails = 0, cyc = 0;

  // bench copy of what it wrote into the tables
  logic        mv  [NS][NE];
  logic [35:0] mk  [NS][NE];
  logic [35:0] mc  [NS][NE];
  logic [2:0]  mp  [NS][NE];
  logic [3:0]  mn  [NS][NE];
  logic [2:0]  ms  [NS][NE];
  logic [31:0] mrv [NS][NE];
  logic [31:0] mrm [NS][NE];
  logic [36:0] expq[$];

  ltm_cache_pipe uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_hdr(in_hdr), .in_tag(in_tag), .out_valid(out_valid),
    .out_ready(out_ready), .out_hdr(out_hdr), .out_tag(out_tag),
    .out_miss(out_miss), .cfg_wr(cfg_wr), .cfg_stage(cfg_stage),
    .cfg_slot(cfg_slot), .cfg_entry_valid(cfg_entry_valid),
    .cfg_key_tag(cfg_key_tag), .cfg_key_hdr(cfg_key_hdr),
    .cfg_care_tag(cfg_care_tag), .cfg_care_hdr(cfg_care_hdr),
    .cfg_prio(cfg_prio), .cfg_next_tag(cfg_next_tag), .cfg_skip(cfg_skip),
    .cfg_set_val(cfg_set_val), .cfg_set_mask(cfg_set_mask)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog: run hung (actual cycle %0d, expected end before 150000)", cyc);
      finish_run();
    end
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [36:0] model(input logic [31:0] hi, input logic [3:0] ti);
    logic [31:0] h; logic [3:0] t; logic m; int skip;
    h = hi; t = ti; m = 1'b0; skip = 0;
    for (int s = 0; s < NS; s++) begin
      if (m || t == 4'hF || skip > 0) begin
        if (skip > 0) skip--;
      end else begin
        bit found; logic [2:0] bp; int sel;
        found = 0; bp = 0; sel = 0;
        for (int e = 0; e < NE; e++)
          if (mv[s][e] && ((({t, h} ^ mk[s][e]) & mc[s][e]) == 36'd0) &&
              (!found || mp[s][e] > bp)) begin
            found = 1; bp = mp[s][e]; sel = e;
          end
        if (found) begin
          h = (h & ~mrm[s][sel]) | (mrv[s][sel] & mrm[s][sel]);
          t = mn[s][sel]; skip = int'(ms[s][sel]);
        end else m = 1'b1;
      end
    end
    return {m, t, h};
  endfunction

  task automatic wr(input int s, input int e, input logic v, input logic [3:0] kt,
                    input logic [31:0] kh, input logic [3:0] ct, input logic [31:0] ch,
                    input logic [2:0] p, input logic [3:0] nt, input logic [2:0] sk,
                    input logic [31:0] rv, input logic [31:0] rm);
    @(negedge clk);
    cfg_wr = 1; cfg_stage = 2'(s); cfg_slot = 3'(e); cfg_entry_valid = v;
    cfg_key_tag = kt; cfg_key_hdr = kh; cfg_care_tag = ct; cfg_care_hdr = ch;
    cfg_prio = p; cfg_next_tag = nt; cfg_skip = sk; cfg_set_val = rv; cfg_set_mask = rm;
    mv[s][e] = v; mk[s][e] = {kt, kh}; mc[s][e] = {ct, ch}; mp[s][e] = p;
    mn[s][e] = nt; ms[s][e] = sk; mrv[s][e] = rv; mrm[s][e] = rm;
    @(negedge clk);
    cfg_wr = 0;
  endtask

  task automatic clear_all();
    for (int s = 0; s < NS; s++)
      for (int e = 0; e < NE; e++)
        wr(s, e, 1'b0, 4'h0, 32'h0, 4'h0, 32'h0, 3'd0, 4'h0, 3'd0, 32'h0, 32'h0);
  endtask

  // one packet with out_ready high; returns {miss,tag,hdr} and latency
  task automatic one_pkt(input logic [31:0] h, input logic [3:0] t,
                         output logic [36:0] res, output int lat);
    @(negedge clk);
    out_ready = 1; in_valid = 1; in_hdr = h; in_tag = t;
    lat = 0;
    @(negedge clk);
    in_valid = 0;
    lat = 1;
    while (!out_valid && lat < 20) begin @(negedge clk); lat++; end
    res = {out_miss, out_tag, out_hdr};
  endtask

  initial begin
    logic [36:0] r; int lat;
    void'($urandom(32'd7531));
    rst_n = 0; in_valid = 0; in_hdr = 0; in_tag = 0; out_ready = 1; cfg_wr = 0;
    cfg_stage = 0; cfg_slot = 0; cfg_entry_valid = 0; cfg_key_tag = 0; cfg_key_hdr = 0;
    cfg_care_tag = 0; cfg_care_hdr = 0; cfg_prio = 0; cfg_next_tag = 0; cfg_skip = 0;
    cfg_set_val = 0; cfg_set_mask = 0;
    for (int s = 0; s < NS; s++)
      for (int e = 0; e < NE; e++) begin
        mv[s][e] = 0; mk[s][e] = 0; mc[s][e] = 0; mp[s][e] = 0;
        mn[s][e] = 0; ms[s][e] = 0; mrv[s][e] = 0; mrm[s][e] = 0;
      end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1: reset state
    chk("R1 out_valid", 64'(out_valid), 64'd0);
    chk("R1 in_ready", 64'(in_ready), 64'd1);
    one_pkt(32'hCAFE0001, 4'h2, r, lat);
    chk("R1 empty tables miss", 64'(r), 64'({1'b1, 4'h2, 32'hCAFE0001}));
    // R9: latency equals stage count
    chk("R9 latency", 64'(lat), 64'(NS));

    // chained segments: R2 R4 R5 R6
    wr(0, 0, 1, 4'h0, 32'h11, 4'hF, 32'hFF, 3'd1, 4'h1, 3'd0, 32'hAA000000, 32'hFF000000);
    wr(1, 0, 1, 4'h1, 32'h0, 4'hF, 32'h0, 3'd1, 4'h2, 3'd0, 32'h00BB0000, 32'h00FF0000);
    wr(2, 0, 1, 4'h2, 32'h0, 4'hF, 32'h0, 3'd1, 4'hF, 3'd0, 32'h0, 32'h0);
    one_pkt(32'h00000011, 4'h0, r, lat);
    chk("R5 R4 R6 chain", 64'(r), 64'({1'b0, 4'hF, 32'hAABB0011}));
    one_pkt(32'h00000012, 4'h0, r, lat);
    chk("R2 R8 header mismatch", 64'(r), 64'({1'b1, 4'h0, 32'h00000012}));
    one_pkt(32'h00000011, 4'h1, r, lat);
    chk("R2 tag in key", 64'(r), 64'({1'b1, 4'h1, 32'h00000011}));
    one_pkt(32'h00000011, 4'hF, r, lat);
    chk("R6 done tag passes", 64'(r), 64'({1'b0, 4'hF, 32'h00000011}));

    // priority: R3 R10
    clear_all();
    wr(0, 0, 0, 4'h0, 32'h0, 4'hF, 32'h0, 3'd7, 4'hF, 3'd0, 32'h9, 32'hF);
    wr(0, 1, 1, 4'h0, 32'h0, 4'hF, 32'h0, 3'd3, 4'hF, 3'd0, 32'h1, 32'hF);
    wr(0, 2, 1, 4'h0, 32'h0, 4'hF, 32'h0, 3'd5, 4'hF, 3'd0, 32'h2, 32'hF);
    wr(0, 3, 1, 4'h0, 32'h0, 4'hF, 32'h0, 3'd5, 4'hF, 3'd0, 32'h3, 32'hF);
    one_pkt(32'hABCD0000, 4'h0, r, lat);
    chk("R3 R10 highest prio, invalid ignored", 64'(r), 64'({1'b0, 4'hF, 32'hABCD0002}));
    wr(0, 1, 1, 4'h0, 32'h0, 4'hF, 32'h0, 3'd5, 4'hF, 3'd0, 32'h1, 32'hF);
    one_pkt(32'hABCD0000, 4'h0, r, lat);
    chk("R3 tie lowest index", 64'(r), 64'({1'b0, 4'hF, 32'hABCD0001}));

    // skip: R7
    clear_all();
    wr(0, 0, 1, 4'h0, 32'h0, 4'hF, 32'h0, 3'd1, 4'h3, 3'd2, 32'h01, 32'hFF);
    wr(1, 0, 1, 4'h3, 32'h0, 4'hF, 32'h0, 3'd1, 4'hF, 3'd0, 32'h0000EE00, 32'h0000FF00);
    wr(2, 0, 1, 4'h3, 32'h0, 4'hF, 32'h0, 3'd1, 4'hF, 3'd0, 32'h0000EE00, 32'h0000FF00);
    wr(3, 0, 1, 4'h3, 32'h0, 4'hF, 32'h0, 3'd1, 4'hF, 3'd0, 32'h00330000, 32'h00FF0000);
    one_pkt(32'h0, 4'h0, r, lat);
    chk("R7 skip two stages", 64'(r), 64'({1'b0, 4'hF, 32'h00330001}));
    wr(0, 0, 1, 4'h0, 32'h0, 4'hF, 32'h0, 3'd1, 4'h3, 3'd3, 32'h01, 32'hFF);
    one_pkt(32'h0, 4'h0, r, lat);
    chk("R7 skip to end", 64'(r), 64'({1'b0, 4'h3, 32'h00000001}));
    wr(0, 0, 0, 4'h0, 32'h0, 4'hF, 32'h0, 3'd1, 4'h3, 3'd3, 32'h01, 32'hFF);
    one_pkt(32'h0, 4'h0, r, lat);
    chk("R10 R8 removed entry misses", 64'(r), 64'({1'b1, 4'h0, 32'h0}));

    // stall: R9 (empty stage 0 entries -> misses, header passes)
    clear_all();
    begin
      int acc; logic [31:0] held;
      acc = 0;
      for (int i = 0; i < 6; i++) begin
        @(negedge clk);
        out_ready = 0; in_valid = 1; in_hdr = 32'h100 + 32'(acc); in_tag = 4'h0;
        #1;
        if (in_ready) acc++;
      end
      chk("R9 accepted while blocked", 64'(acc), 64'(NS));
      chk("R9 in_ready low when full", 64'(in_ready), 64'd0);
      held = out_hdr;
      @(negedge clk); in_valid = 0;
      repeat (3) @(negedge clk);
      chk("R9 output held", 64'(out_hdr), 64'(held));
      for (int i = 0; i < NS; i++) begin
        @(negedge clk);
        out_ready = 1;
        #1;
        chk("R9 in order after stall", 64'({out_valid, out_hdr}), 64'({1'b1, 32'h100 + 32'(i)}));
      end
      @(negedge clk);
    end

    // random tables and traffic, scored by model (R2..R9)
    for (int round = 0; round < 4; round++) begin
      for (int s = 0; s < NS; s++)
        for (int e = 0; e < NE; e++)
          wr(s, e, ($urandom % 4) != 0, 4'($urandom % 4), $urandom, 4'hF,
             (32'h1 << ($urandom % 32)) | (32'h1 << ($urandom % 32)),
             3'($urandom % 8), (($urandom % 5) == 0) ? 4'hF : 4'($urandom % 4),
             3'($urandom % 3), $urandom, $urandom);
      for (int c = 0; c < 1500; c++) begin
        @(negedge clk);
        out_ready = ($urandom % 4) != 0;
        in_valid  = ($urandom % 5) != 0;
        in_hdr    = $urandom;
        in_tag    = (($urandom % 6) == 0) ? 4'hF : 4'($urandom % 4);
        #1;
        if (out_valid && out_ready) begin
          if (expq.size() == 0) chk("R9 unexpected output", 64'd1, 64'd0);
          else chk("R2-model random result", 64'({out_miss, out_tag, out_hdr}), 64'(expq.pop_front()));
        end
        if (in_valid && in_ready) expq.push_back(model(in_hdr, in_tag));
      end
      for (int c = 0; c < NS + 3; c++) begin
        @(negedge clk);
        out_ready = 1; in_valid = 0;
        #1;
        if (out_valid) begin
          if (expq.size() == 0) chk("R9 unexpected output", 64'd1, 64'd0);
          else chk("R4 R5 drained result", 64'({out_miss, out_tag, out_hdr}), 64'(expq.pop_front()));
        end
      end
      chk("R9 all results delivered", 64'(expq.size()), 64'd0);
    end
    finish_run();
  end
endmodule